// File: doc/BRIEF.md
# Frame-Gated Transmit Word Queue

This block is a single-clock queue of 32-bit words placed between a host that writes outgoing frames and a transmit engine that drains them. Each word carries a count of how many of its bytes are meaningful (0 to 4) and a flag marking the final word of a frame. The queue holds back the first word of each frame until that frame has enough bytes stored to meet a programmable start size, or until its final word has been stored. After that point the frame drains without further gating. The block also reports its occupancy in words and drives two occupancy-threshold flags whose thresholds are set by software.

Three 8-bit settings are written through a plain write strobe with a 2-bit select. Select 0 sets the low-water threshold in words. Select 1 sets the high-water threshold in words. Select 2 sets the start size in bytes. Select 3 has no effect. All three settings reset to zero.

Both data sides use a valid/ready handshake. A word moves on a clock edge where valid and ready are both high. On the read side, `out_valid` stays low while the head frame is gated, and once it rises it stays high until the word is taken. The write side does not stall the source: `in_ready` is high only when the queue is not full. A word offered while `in_ready` is low is dropped, and the drop is recorded in a sticky flag.

Top module: `txq_gated_fifo`

## Requirements
- R1: After reset the occupancy is 0, `out_valid` is 0, `overflow` is 0, `in_ready` is 1, and all three settings are 0, so `fifo_pe` and `fifo_pf` are both 1.
- R2: Words leave in the order they were accepted, with data, byte count and last flag unchanged. The occupancy equals accepted writes minus completed reads.
- R3: `in_ready` is low exactly when the occupancy is 64. A word offered while `in_ready` is low leaves contents and occupancy unchanged and sets `overflow`, which stays set until reset.
- R4: Asserting `out_ready` while `out_valid` is low removes nothing. The occupancy and the head word are unchanged.
- R5: `fifo_pe` is 1 exactly when the occupancy in words is less than or equal to the setting at select 0.
- R6: `fifo_pf` is 1 exactly when the occupancy in words is greater than or equal to the setting at select 1.
- R7: While the head frame has not started and its final word is not stored, `out_valid` stays 0 as long as the sum of `in_bytes` over its stored words is below the setting at select 2.
- R8: As soon as that byte sum reaches the start size, `out_valid` rises in the cycle after the word that reaches it is accepted.
- R9: A head frame whose final word is stored may be read even if its total length is below the start size. This also applies to a frame stored behind the current head once the head has drained.
- R10: Once the first word of a frame has been read, the rest of that frame is not gated again, even if the start size is raised.
- R11: With a start size of 0, a frame's first word may be read in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 2 | Settings select: 0 low-water, 1 high-water, 2 start size |
| cfg_wdata | input | 8 | Settings write value |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Queue can accept a word (not full) |
| in_data | input | 32 | Write word data |
| in_bytes | input | 3 | Meaningful bytes in the write word (0 to 4) |
| in_last | input | 1 | Write word ends its frame |
| out_valid | output | 1 | Head word may be taken |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 32 | Head word data |
| out_bytes | output | 3 | Meaningful bytes in the head word |
| out_last | output | 1 | Head word ends its frame |
| level | output | 7 | Stored words, 0 to 64 |
| fifo_pe | output | 1 | Occupancy at or below the low-water threshold |
| fifo_pf | output | 1 | Occupancy at or above the high-water threshold |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The case that is hardest to reach from the ports is a gated head frame stored behind a complete frame. The byte sum of that second frame must be correct at the moment the first frame finishes draining. The stimulus writes a short complete frame and then one partial word of the next frame while the start size is above that word's bytes. It then drains the first frame and confirms that `out_valid` drops and stays low until the second frame's final word arrives. A second hard case is the re-gating exemption. The bench starts a frame, raises the start size far above the frame length in the middle of the frame, and checks that the remaining words still flow.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int DATA_W = 32;
  localparam int NB_W   = 3;
  localparam int THR_W  = 8;

  typedef enum logic [1:0] {
    SEL_LOW_WATER  = 2'd0,
    SEL_HIGH_WATER = 2'd1,
    SEL_START_SIZE = 2'd2,
    SEL_UNUSED     = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [NB_W-1:0]   nbytes;
    logic              last;
  } txq_word_t;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  txq_pkg::txq_word_t  wr_word,
  input  logic                pop,
  output txq_pkg::txq_word_t  rd_word,
  output logic [LW-1:0]       level,
  output logic                full,
  output logic                empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  txq_pkg::txq_word_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rd_word = mem[rd_ptr];
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);

endmodule

// File: rtl/txq_cfg_regs.sv
module txq_cfg_regs #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [THR_W-1:0] cfg_wdata,
  output logic [THR_W-1:0] low_thr,
  output logic [THR_W-1:0] high_thr,
  output logic [THR_W-1:0] start_thr
);
  import txq_pkg::*;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_thr   <= '0;
      high_thr  <= '0;
      start_thr <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_LOW_WATER:  low_thr   <= cfg_wdata;
        SEL_HIGH_WATER: high_thr  <= cfg_wdata;
        SEL_START_SIZE: start_thr <= cfg_wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/txq_level_flags.sv
module txq_level_flags #(
  parameter int LW    = 7,
  parameter int THR_W = 8
) (
  input  logic [LW-1:0]    level,
  input  logic [THR_W-1:0] low_thr,
  input  logic [THR_W-1:0] high_thr,
  output logic             at_or_below_low,
  output logic             at_or_above_high
);
  localparam int CW = (LW > THR_W) ? LW : THR_W;

  logic [CW-1:0] lvl_w, low_w, high_w;

  assign lvl_w  = CW'(level);
  assign low_w  = CW'(low_thr);
  assign high_w = CW'(high_thr);

  assign at_or_below_low  = (lvl_w <= low_w);
  assign at_or_above_high = (lvl_w >= high_w);

endmodule

// File: rtl/txq_start_gate.sv
module txq_start_gate #(
  parameter int LW    = 7,
  parameter int THR_W = 8,
  parameter int NB_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NB_W-1:0]  push_bytes,
  input  logic             push_last,
  input  logic             pop,
  input  logic             pop_last,
  input  logic [THR_W-1:0] start_thr,
  output logic             gate_open
);
  localparam int SW   = THR_W + 1;
  localparam int SUMW = SW + 1;

  logic [SW-1:0]   open_bytes;
  logic [LW-1:0]   frames_stored;
  logic            started;
  logic [SUMW-1:0] sum_wide;
  logic [SW-1:0]   sum_sat;

  assign sum_wide = SUMW'(open_bytes) + SUMW'(push_bytes);
  assign sum_sat  = sum_wide[SUMW-1] ? '1 : sum_wide[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_bytes    <= '0;
      frames_stored <= '0;
      started       <= 1'b0;
    end else begin
      if (push) open_bytes <= push_last ? '0 : sum_sat;
      case ({push && push_last, pop && pop_last})
        2'b10:   frames_stored <= frames_stored + 1'b1;
        2'b01:   frames_stored <= frames_stored - 1'b1;
        default: frames_stored <= frames_stored;
      endcase
      if (pop) started <= !pop_last;
    end
  end

  assign gate_open = started
                   || (frames_stored != '0)
                   || (open_bytes >= SW'(start_thr));

endmodule

// File: rtl/txq_gated_fifo.sv
module txq_gated_fifo #(
  parameter int DEPTH = 64,
  parameter int THR_W = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [THR_W-1:0]           cfg_wdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [txq_pkg::DATA_W-1:0] in_data,
  input  logic [txq_pkg::NB_W-1:0]   in_bytes,
  input  logic                       in_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [txq_pkg::DATA_W-1:0] out_data,
  output logic [txq_pkg::NB_W-1:0]   out_bytes,
  output logic                       out_last,
  output logic [LW-1:0]              level,
  output logic                       fifo_pe,
  output logic                       fifo_pf,
  output logic                       overflow
);
  import txq_pkg::*;

  logic            full, empty, push, pop, gate_open;
  txq_word_t       wr_word, rd_word;
  logic [THR_W-1:0] low_thr, high_thr, start_thr;

  assign wr_word = '{data: in_data, nbytes: in_bytes, last: in_last};
  assign push    = in_valid && !full;
  assign pop     = out_valid && out_ready;

  txq_store #(.DEPTH(DEPTH), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wr_word(wr_word),
    .pop(pop), .rd_word(rd_word),
    .level(level), .full(full), .empty(empty)
  );

  txq_cfg_regs #(.THR_W(THR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .low_thr(low_thr), .high_thr(high_thr), .start_thr(start_thr)
  );

  txq_level_flags #(.LW(LW), .THR_W(THR_W)) u_flags (
    .level(level), .low_thr(low_thr), .high_thr(high_thr),
    .at_or_below_low(fifo_pe), .at_or_above_high(fifo_pf)
  );

  txq_start_gate #(.LW(LW), .THR_W(THR_W), .NB_W(NB_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_bytes(in_bytes), .push_last(in_last),
    .pop(pop), .pop_last(rd_word.last),
    .start_thr(start_thr), .gate_open(gate_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (in_valid && full) overflow <= 1'b1;
  end

  assign in_ready  = !full;
  assign out_valid = !empty && gate_open;
  assign out_data  = rd_word.data;
  assign out_bytes = rd_word.nbytes;
  assign out_last  = rd_word.last;

endmodule

// File: rtl/txq_gated_fifo_chk.sv
module txq_gated_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] level,
  input logic          fifo_pe,
  input logic          fifo_pf,
  input logic          overflow
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);  // R3

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);  // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> int'(level) == int'($past(level)) + int'($past(in_valid && in_ready))
                             - int'($past(out_valid && out_ready)));  // R2

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !out_valid);  // R4

  AST_PE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> fifo_pe);  // R5

  AST_PF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == DEPTH) |-> fifo_pf);  // R6

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_we) |=> out_valid);  // R10

endmodule

bind txq_gated_fifo txq_gated_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .level(level), .fifo_pe(fifo_pe), .fifo_pf(fifo_pf), .overflow(overflow)
);

// File: tb/txq_gated_fifo_test.sv
module txq_gated_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_bytes = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;
  logic        out_last;
  logic [6:0]  level;
  logic        fifo_pe, fifo_pf, overflow;

  int n_chk = 0;
  int n_err = 0;

  txq_gated_fifo uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_bytes(out_bytes), .out_last(out_last), .level(level),
    .fifo_pe(fifo_pe), .fifo_pf(fifo_pf), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic [2:0] b, input logic l);
    in_valid = 1'b1; in_data = d; in_bytes = b; in_last = l;
    step();
    in_valid = 1'b0;
  endtask

  task automatic take(input string tag, input logic [31:0] d,
                      input logic [2:0] b, input logic l);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " data"}, out_data, d);
    chk({tag, " bytes/last"}, {28'd0, out_bytes, out_last}, {28'd0, b, l});
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", 32'(level), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 pe/pf", {30'd0, fifo_pe, fifo_pf}, 32'd3);
  endtask

  task automatic t_zero_start();
    push(32'hA000_0001, 3'd4, 1'b0);
    chk("R11 valid after first word", 32'(out_valid), 1);
    push(32'hA000_0002, 3'd4, 1'b0);
    push(32'hA000_0003, 3'd2, 1'b1);
    chk("R2 level 3", 32'(level), 3);
    take("R2 w1", 32'hA000_0001, 3'd4, 1'b0);
    take("R2 w2", 32'hA000_0002, 3'd4, 1'b0);
    take("R2 w3", 32'hA000_0003, 3'd2, 1'b1);
    chk("R2 drained", 32'(level), 0);
  endtask

  task automatic t_threshold_gate();
    cfg(2'd2, 8'd10);
    push(32'hB000_0001, 3'd4, 1'b0);
    chk("R7 4 of 10 bytes", 32'(out_valid), 0);
    push(32'hB000_0002, 3'd4, 1'b0);
    chk("R7 8 of 10 bytes", 32'(out_valid), 0);
    push(32'hB000_0003, 3'd2, 1'b0);
    chk("R8 10 of 10 bytes", 32'(out_valid), 1);
    take("R8 b1", 32'hB000_0001, 3'd4, 1'b0);
    cfg(2'd2, 8'd200);
    chk("R10 no regate after raise", 32'(out_valid), 1);
    take("R10 b2", 32'hB000_0002, 3'd4, 1'b0);
    take("R10 b3", 32'hB000_0003, 3'd2, 1'b0);
    chk("R10 empty mid-frame", 32'(out_valid), 0);
    push(32'hB000_0004, 3'd1, 1'b1);
    take("R10 b4", 32'hB000_0004, 3'd1, 1'b1);
  endtask

  task automatic t_short_frame();
    cfg(2'd2, 8'd10);
    push(32'hC000_0001, 3'd4, 1'b0);
    chk("R7 short frame held", 32'(out_valid), 0);
    push(32'hC000_0002, 3'd4, 1'b1);
    chk("R9 complete short frame", 32'(out_valid), 1);
    push(32'hD000_0001, 3'd4, 1'b0);
    take("R9 c1", 32'hC000_0001, 3'd4, 1'b0);
    take("R9 c2", 32'hC000_0002, 3'd4, 1'b1);
    chk("R7 second frame gated", 32'(out_valid), 0);
    chk("R7 second frame stored", 32'(level), 1);
    push(32'hD000_0002, 3'd3, 1'b1);
    chk("R9 second frame complete", 32'(out_valid), 1);
    take("R9 d1", 32'hD000_0001, 3'd4, 1'b0);
    take("R9 d2", 32'hD000_0002, 3'd3, 1'b1);
  endtask

  task automatic t_ignored_read();
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk("R4 empty read level", 32'(level), 0);
    cfg(2'd2, 8'd100);
    push(32'hE000_0001, 3'd4, 1'b0);
    out_ready = 1'b1;
    step();
    step();
    out_ready = 1'b0;
    chk("R4 gated read level", 32'(level), 1);
    push(32'hE000_0002, 3'd4, 1'b1);
    take("R4 head kept", 32'hE000_0001, 3'd4, 1'b0);
    take("R4 e2", 32'hE000_0002, 3'd4, 1'b1);
  endtask

  task automatic t_flags();
    cfg(2'd2, 8'd0);
    cfg(2'd0, 8'd2);
    cfg(2'd1, 8'd4);
    chk("R5/R6 level 0", {30'd0, fifo_pe, fifo_pf}, 32'd2);
    push(32'h1, 3'd4, 1'b1);
    push(32'h2, 3'd4, 1'b1);
    chk("R5 level 2 pe", 32'(fifo_pe), 1);
    push(32'h3, 3'd4, 1'b1);
    chk("R5 level 3 pe", 32'(fifo_pe), 0);
    chk("R6 level 3 pf", 32'(fifo_pf), 0);
    push(32'h4, 3'd4, 1'b1);
    chk("R6 level 4 pf", 32'(fifo_pf), 1);
    for (int i = 1; i <= 4; i++) take("R2 flag drain", 32'(i), 3'd4, 1'b1);
    chk("R5 back to empty", {30'd0, fifo_pe, fifo_pf}, 32'd2);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(32'h5000_0000 + 32'(i), 3'd4, 1'b1);
    chk("R3 level full", 32'(level), DEPTH);
    chk("R3 in_ready low", 32'(in_ready), 0);
    chk("R3 overflow clear", 32'(overflow), 0);
    push(32'hDEAD_BEEF, 3'd4, 1'b1);
    chk("R3 overflow set", 32'(overflow), 1);
    chk("R3 level unchanged", 32'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) take("R3 drain", 32'h5000_0000 + 32'(i), 3'd4, 1'b1);
    chk("R3 dropped word absent", 32'(out_valid), 0);
    chk("R3 overflow sticky", 32'(overflow), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_zero_start();
    t_threshold_gate();
    t_short_frame();
    t_ignored_read();
    t_flags();
    t_full();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule